// File: doc/BRIEF.md
# ADC Gain and Offset Calibration with Overload Flag

This block sits in a sigma-delta converter data path behind the decimation chain. Each decimated sample arrives with a valid strobe. The block multiplies the sample by a programmable gain and then adds a programmable offset. It returns a saturated signed result with its own valid strobe, a fixed two clock cycles later.

A separate watcher raises a sticky overload flag from two sources. The first source compares the magnitude of the early, first-stage filter output against a programmable threshold, so the flag does not wait for calibration. The second source trips when the per-sample overload indication at the modulator rate stays set for a run of consecutive samples. The flag stays set until a clear pulse. Three 16-bit settings are loaded through a plain address, data and write-enable port.

Top module: `adc_cal_ovr`

## Requirements
- R1: After reset the offset setting is 0x0000, the gain is 0xA000 (1.25), the overload threshold is 0xCCCC, and out_valid, out_sample and ovr_flag are all 0.
- R2: The result is floor(sample * gain / 2^15) + floor(offset / 2^7). The sample and the offset are signed 16-bit values and the gain is unsigned 16-bit, so a gain of 0x8000 passes the sample through unchanged.
- R3: The offset term is added to the gain-scaled sample and is never scaled by the gain. For example, gain 0x4000 with offset 0x7FFF maps 1000 to 755.
- R4: A result above 32767 is output as 0x7FFF, and a result below -32768 is output as 0x8000. No intermediate value wraps around.
- R5: out_valid is high exactly two cycles after in_valid was sampled high. Back-to-back samples produce back-to-back results. out_sample holds its value while out_valid is low.
- R6: A cycle with cfg_we high writes cfg_wdata to one setting: address 3 is the offset, address 4 is the gain and address 5 is the threshold. Writes to any other address change nothing.
- R7: When stage1_valid is high, ovr_flag is set at the next edge if twice the unsigned magnitude of stage1_sample is strictly greater than the threshold. Equality does not set it. A sample of -32768 has magnitude 32768.
- R8: The threshold comparison uses stage1_sample only and does not depend on the gain or the offset settings.
- R9: ovr_flag is set on a mod_tick with mod_over high when that tick completes more than 4 consecutive overloaded ticks. A tick with mod_over low restarts the count. Cycles without mod_tick leave the count unchanged.
- R10: ovr_flag stays set until an ovr_clear pulse clears it at the next edge. A new overload in the same cycle as the clear keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Setting write enable |
| cfg_addr | input | 3 | Setting address |
| cfg_wdata | input | 16 | Setting write data |
| in_valid | input | 1 | Decimated sample valid |
| in_sample | input | 16 | Decimated signed sample |
| out_valid | output | 1 | Corrected sample valid |
| out_sample | output | 16 | Corrected, saturated signed sample |
| stage1_valid | input | 1 | First-stage filter output valid |
| stage1_sample | input | 16 | First-stage filter signed output |
| mod_tick | input | 1 | Modulator-rate sample strobe |
| mod_over | input | 1 | Modulator sample overloaded |
| ovr_clear | input | 1 | Status read-clear pulse for the overload flag |
| ovr_flag | output | 1 | Sticky overload flag |

## Verification
The bench builds the block with its default parameters: a 7-bit offset shift and a run limit of 4, with 16-bit words. At these values both saturation rails and the -32768 magnitude corner can be reached with single samples. The bench drives 16-bit extremes through gains of 0.5, 1.0, 1.25 and nearly 2.0. The fifth-tick trip point and the restart of the count take only a handful of modulator ticks to reach, so each run boundary is crossed from both sides.

// File: rtl/adcc_pkg.sv
package adcc_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_OFFSET = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_GAIN   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_THRESH = 3'd5;

  localparam logic [REG_W-1:0] OFFSET_RST = 16'h0000;
  localparam logic [REG_W-1:0] GAIN_RST   = 16'hA000;
  localparam logic [REG_W-1:0] THRESH_RST = 16'hCCCC;

  typedef struct packed {
    logic [REG_W-1:0] offset;
    logic [REG_W-1:0] gain;
    logic [REG_W-1:0] thresh;
  } cal_cfg_t;
endpackage

// File: rtl/adcc_rst_sync.sv
module adcc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/adcc_regs.sv
module adcc_regs
  import adcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output cal_cfg_t          cfg
);
  cal_cfg_t cfg_q;
  cal_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    case (addr)
      ADDR_OFFSET: cfg_d.offset = wdata;
      ADDR_GAIN:   cfg_d.gain   = wdata;
      ADDR_THRESH: cfg_d.thresh = wdata;
      default:     cfg_d = cfg_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.offset <= OFFSET_RST;
      cfg_q.gain   <= GAIN_RST;
      cfg_q.thresh <= THRESH_RST;
    end else if (we) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/adcc_datapath.sv
module adcc_datapath #(
  parameter int unsigned W         = 16,
  parameter int unsigned OFF_SHIFT = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_sample,
  input  logic [W-1:0] gain,
  input  logic [W-1:0] offset,
  output logic         out_valid,
  output logic [W-1:0] out_sample
);
  // product width, scaled width (one guard bit past gain 2.0), sum width
  localparam int unsigned PW = 2 * W + 1;
  localparam int unsigned SW = W + 2;
  localparam int unsigned TW = SW + 1;
  localparam logic signed [W-1:0]  MAX_W = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0]  MIN_W = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [TW-1:0] MAX_T = TW'(MAX_W);
  localparam logic signed [TW-1:0] MIN_T = TW'(MIN_W);

  // stage 1: multiply and rescale
  logic signed [PW-1:0] samp_ext;
  logic signed [PW-1:0] gain_ext;
  logic signed [PW-1:0] prod;
  logic signed [SW-1:0] scaled_d;
  logic signed [SW-1:0] scaled_q;
  logic                 v1_q;

  assign samp_ext = PW'($signed(in_sample));
  assign gain_ext = PW'({1'b0, gain});
  assign prod     = samp_ext * gain_ext;
  assign scaled_d = SW'(prod >>> (W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v1_q <= 1'b0;
    else        v1_q <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        scaled_q <= '0;
    else if (in_valid) scaled_q <= scaled_d;
  end

  // stage 2: offset add and saturate
  logic signed [TW-1:0] off_term;
  logic signed [TW-1:0] sum;
  logic        [W-1:0]  sat_d;
  logic        [W-1:0]  out_q;
  logic                 v2_q;

  assign off_term = TW'($signed(offset) >>> OFF_SHIFT);
  assign sum      = TW'(scaled_q) + off_term;

  always_comb begin
    if (sum > MAX_T)      sat_d = MAX_W;
    else if (sum < MIN_T) sat_d = MIN_W;
    else                  sat_d = sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v2_q <= 1'b0;
    else        v2_q <= v1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    out_q <= '0;
    else if (v1_q) out_q <= sat_d;
  end

  assign out_valid  = v2_q;
  assign out_sample = out_q;
endmodule

// File: rtl/adcc_ovr.sv
module adcc_ovr #(
  parameter int unsigned W         = 16,
  parameter int unsigned RUN_LIMIT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s1_valid,
  input  logic [W-1:0] s1_sample,
  input  logic [W-1:0] thresh,
  input  logic         mod_tick,
  input  logic         mod_over,
  input  logic         clear,
  output logic         flag
);
  localparam int unsigned CW = $clog2(RUN_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(RUN_LIMIT);

  // early threshold path: doubled magnitude against a full-scale fraction
  logic [W-1:0] mag;
  logic [W:0]   mag2;
  logic         thr_hit;

  assign mag     = s1_sample[W-1] ? (~s1_sample + W'(1)) : s1_sample;
  assign mag2    = {mag, 1'b0};
  assign thr_hit = s1_valid && (mag2 > {1'b0, thresh});

  // modulator-rate run counter, saturating at the limit
  logic [CW-1:0] run_q;
  logic [CW-1:0] run_d;
  logic          run_trip;

  always_comb begin
    run_d = run_q;
    if (mod_tick) begin
      if (!mod_over)         run_d = '0;
      else if (run_q != LIM) run_d = run_q + CW'(1);
    end
  end

  assign run_trip = mod_tick && mod_over && (run_q == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (mod_tick) run_q <= run_d;
  end

  // sticky flag, set wins over clear
  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = (flag_q && !clear) || thr_hit || run_trip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/adc_cal_ovr.sv
module adc_cal_ovr
  import adcc_pkg::*;
#(
  parameter int unsigned OFF_SHIFT = 7,
  parameter int unsigned RUN_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              in_valid,
  input  logic [REG_W-1:0]  in_sample,
  output logic              out_valid,
  output logic [REG_W-1:0]  out_sample,
  input  logic              stage1_valid,
  input  logic [REG_W-1:0]  stage1_sample,
  input  logic              mod_tick,
  input  logic              mod_over,
  input  logic              ovr_clear,
  output logic              ovr_flag
);
  logic     rst_core_n;
  cal_cfg_t cfg;

  adcc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  adcc_regs u_regs (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  adcc_datapath #(.W(REG_W), .OFF_SHIFT(OFF_SHIFT)) u_dp (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .gain       (cfg.gain),
    .offset     (cfg.offset),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  adcc_ovr #(.W(REG_W), .RUN_LIMIT(RUN_LIMIT)) u_ovr (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .s1_valid  (stage1_valid),
    .s1_sample (stage1_sample),
    .thresh    (cfg.thresh),
    .mod_tick  (mod_tick),
    .mod_over  (mod_over),
    .clear     (ovr_clear),
    .flag      (ovr_flag)
  );
endmodule

// File: rtl/adc_cal_ovr_chk.sv
module adc_cal_ovr_chk #(
  parameter int unsigned W         = 16,
  parameter int unsigned RUN_LIMIT = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         out_valid,
  input logic [W-1:0] out_sample,
  input logic         stage1_valid,
  input logic         mod_tick,
  input logic         mod_over,
  input logic         ovr_clear,
  input logic         ovr_flag
);
  // independent count of consecutive overloaded modulator ticks
  int unsigned run_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_seen <= 0;
    else if (mod_tick) begin
      if (!mod_over)                  run_seen <= 0;
      else if (run_seen < RUN_LIMIT)  run_seen <= run_seen + 1;
    end
  end

  // R5: a result strobe always traces back to an input strobe two cycles earlier
  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  // R5: the output word only moves together with a result strobe
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sample));

  // R10: flag persists without a clear
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clear) |=> ovr_flag);

  // R10: a clear with no overload source active drops the flag
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clear && !stage1_valid && !mod_tick) |=> !ovr_flag);

  // R7, R9: the flag only rises after an input event that can cause it
  assert_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(stage1_valid || mod_tick));

  // R9: a run longer than the limit sets the flag
  assert_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_tick && mod_over && (run_seen >= RUN_LIMIT)) |=> ovr_flag);
endmodule

bind adc_cal_ovr adc_cal_ovr_chk #(.W(adcc_pkg::REG_W), .RUN_LIMIT(RUN_LIMIT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .in_valid     (in_valid),
  .out_valid    (out_valid),
  .out_sample   (out_sample),
  .stage1_valid (stage1_valid),
  .mod_tick     (mod_tick),
  .mod_over     (mod_over),
  .ovr_clear    (ovr_clear),
  .ovr_flag     (ovr_flag)
);

// File: tb/adc_cal_ovr_bench.sv
module adc_cal_ovr_bench;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        in_valid;
  logic [15:0] in_sample;
  logic        out_valid;
  logic [15:0] out_sample;
  logic        stage1_valid;
  logic [15:0] stage1_sample;
  logic        mod_tick;
  logic        mod_over;
  logic        ovr_clear;
  logic        ovr_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench-side copies of the settings, updated only through legal writes
  logic [15:0] m_gain   = 16'hA000;
  logic [15:0] m_offset = 16'h0000;

  adc_cal_ovr u_adc_cal_ovr (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample),
    .stage1_valid(stage1_valid), .stage1_sample(stage1_sample),
    .mod_tick(mod_tick), .mod_over(mod_over), .ovr_clear(ovr_clear),
    .ovr_flag(ovr_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [15:0] model(input logic [15:0] x, input logic [15:0] g,
                                        input logic [15:0] o);
    longint p;
    p = longint'($signed(x)) * longint'({48'd0, g});
    p = p >>> 15;
    p = p + (longint'($signed(o)) >>> 7);
    if (p > 32767)  p = 32767;
    if (p < -32768) p = -32768;
    return p[15:0];
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 3'd3) m_offset = d;
    if (a == 3'd4) m_gain   = d;
  endtask

  task automatic send(input logic [15:0] x, input string req);
    in_valid = 1'b1; in_sample = x;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, "out_valid one cycle after input", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check(req, "out_valid two cycles after input", {31'd0, out_valid}, 32'd1);
    check(req, "out_sample", {16'd0, out_sample}, {16'd0, model(x, m_gain, m_offset)});
  endtask

  task automatic s1(input logic [15:0] x);
    stage1_valid = 1'b1; stage1_sample = x;
    @(negedge clk);
    stage1_valid = 1'b0;
  endtask

  task automatic tick(input logic over);
    mod_tick = 1'b1; mod_over = over;
    @(negedge clk);
    mod_tick = 1'b0; mod_over = 1'b0;
  endtask

  task automatic clr();
    ovr_clear = 1'b1;
    @(negedge clk);
    ovr_clear = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R1", "out_sample after reset", {16'd0, out_sample}, 32'd0);
    check("R1", "ovr_flag after reset", {31'd0, ovr_flag}, 32'd0);
    send(16'd1000, "R1");   // 1.25 gain, zero offset -> 1250
    send(16'hFFFD, "R2");   // -3 * 1.25 floors to -4
  endtask

  task automatic t_default_thresh();
    s1(16'd26214);
    check("R1", "flag at magnitude equal to default threshold", {31'd0, ovr_flag}, 32'd0);
    s1(16'd26215);
    check("R7", "flag above default threshold", {31'd0, ovr_flag}, 32'd1);
    clr();
    s1(16'h8000);
    check("R7", "flag for -32768", {31'd0, ovr_flag}, 32'd1);
    clr();
    check("R10", "flag after clear", {31'd0, ovr_flag}, 32'd0);
  endtask

  task automatic t_unity_offset();
    wr(3'd4, 16'h8000);
    send(16'd1234, "R2");
    send(16'h8000, "R2");
    wr(3'd3, 16'h8000);
    send(16'd100, "R2");    // 100 - 256
  endtask

  task automatic t_order();
    wr(3'd4, 16'h4000);
    wr(3'd3, 16'h7FFF);
    send(16'd1000, "R3");   // 500 + 255 = 755
    send(16'hFFFF, "R3");   // -1 + 255
  endtask

  task automatic t_saturate();
    wr(3'd4, 16'hA000);
    wr(3'd3, 16'h0000);
    send(16'd30000, "R4");
    send(16'h8AD0, "R4");   // -30000
    wr(3'd4, 16'hFFFF);
    wr(3'd3, 16'h7FFF);
    send(16'h7FFF, "R4");
    wr(3'd3, 16'h8000);
    send(16'h8000, "R4");
  endtask

  task automatic t_burst();
    logic [15:0] xs [3];
    xs[0] = 16'd7; xs[1] = 16'hFF00; xs[2] = 16'd4096;
    wr(3'd4, 16'h8000);
    wr(3'd3, 16'h0000);
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_sample = xs[i];
      @(negedge clk);
      if (i > 0) begin
        check("R5", "burst valid", {31'd0, out_valid}, 32'd1);
        check("R5", "burst data", {16'd0, out_sample}, {16'd0, xs[i-1]});
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    check("R5", "burst last valid", {31'd0, out_valid}, 32'd1);
    check("R5", "burst last data", {16'd0, out_sample}, {16'd0, xs[2]});
    @(negedge clk);
    check("R5", "valid drops", {31'd0, out_valid}, 32'd0);
    check("R5", "data held", {16'd0, out_sample}, {16'd0, xs[2]});
  endtask

  task automatic t_bad_addr();
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0000);
    wr(3'd6, 16'h0000);
    wr(3'd7, 16'h0000);
    send(16'd1000, "R6");   // still unity gain, zero offset
    s1(16'd100);
    check("R6", "threshold untouched by stray writes", {31'd0, ovr_flag}, 32'd0);
  endtask

  task automatic t_prog_thresh();
    wr(3'd5, 16'h1000);
    s1(16'd2048);
    check("R7", "equal doubled magnitude", {31'd0, ovr_flag}, 32'd0);
    s1(16'hF800);           // -2048
    check("R7", "equal negative", {31'd0, ovr_flag}, 32'd0);
    s1(16'hF7FF);           // -2049
    check("R7", "above programmed threshold", {31'd0, ovr_flag}, 32'd1);
    clr();
  endtask

  task automatic t_indep();
    wr(3'd4, 16'h0000);
    wr(3'd3, 16'h8000);
    s1(16'd2049);
    check("R8", "threshold ignores gain and offset", {31'd0, ovr_flag}, 32'd1);
    clr();
    wr(3'd4, 16'hFFFF);
    s1(16'd2000);
    check("R8", "large gain does not trip", {31'd0, ovr_flag}, 32'd0);
  endtask

  task automatic t_run();
    for (int i = 0; i < 4; i++) begin
      tick(1'b1);
      check("R9", "run below limit", {31'd0, ovr_flag}, 32'd0);
    end
    tick(1'b1);
    check("R9", "fifth overloaded tick", {31'd0, ovr_flag}, 32'd1);
    clr();
    tick(1'b0);
    check("R9", "restart tick", {31'd0, ovr_flag}, 32'd0);
    for (int i = 0; i < 3; i++) tick(1'b1);
    repeat (3) @(negedge clk);
    tick(1'b1);
    check("R9", "gaps keep count", {31'd0, ovr_flag}, 32'd0);
    tick(1'b1);
    check("R9", "run across gaps trips", {31'd0, ovr_flag}, 32'd1);
    clr();
    tick(1'b0);
    for (int i = 0; i < 4; i++) tick(1'b1);
    tick(1'b0);
    for (int i = 0; i < 4; i++) tick(1'b1);
    check("R9", "broken run does not trip", {31'd0, ovr_flag}, 32'd0);
    tick(1'b1);
    check("R9", "fresh run trips", {31'd0, ovr_flag}, 32'd1);
    clr();
    tick(1'b0);
  endtask

  task automatic t_sticky();
    s1(16'd3000);
    repeat (3) @(negedge clk);
    check("R10", "flag held", {31'd0, ovr_flag}, 32'd1);
    ovr_clear = 1'b1; stage1_valid = 1'b1; stage1_sample = 16'd3000;
    @(negedge clk);
    ovr_clear = 1'b0; stage1_valid = 1'b0;
    check("R10", "set wins over clear", {31'd0, ovr_flag}, 32'd1);
    clr();
    check("R10", "clear alone", {31'd0, ovr_flag}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_sample = '0; stage1_valid = 1'b0; stage1_sample = '0;
    mod_tick = 1'b0; mod_over = 1'b0; ovr_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_default_thresh();
    t_unity_offset();
    t_order();
    t_saturate();
    t_burst();
    t_bad_addr();
    t_prog_thresh();
    t_indep();
    t_run();
    t_sticky();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule